// File: doc/BRIEF.md
# Channel-Mapped Interrupt Prioritizer

This block turns a vector of pending interrupt sources into two host requests. Each source is assigned one of 32 priority channels through a byte-wide entry in a small bank of writable map words. Every cycle the block picks, for each host output, the pending source whose channel has the smallest number. It then registers a request flag, the winning source index and the winning channel.

Channels 0 and 1 feed the fast request and channels 2 to 31 feed the normal request, so both requests can be raised at once. An entry that holds a value above 31 takes its source out of arbitration. Software sets the map through a plain single-cycle write strobe and can read any map word back through a combinational read path. The pending vector and the host outputs are level signals sampled or driven every cycle. They have no valid/ready handshake, so no back-pressure exists: a result is replaced on the next clock edge whether or not it has been consumed.

Top module: `cmip_prioritizer`

## Requirements
- R1: After reset every map word reads 0x0F0F0F0F, and both requests are low with source and channel outputs at zero.
- R2: The entry for source s sits in map word s/4 at bits 8*(s%4)+7 down to 8*(s%4). A write to a valid address replaces the whole word and reads back unchanged.
- R3: Among pending sources within one host band, the source with the numerically smallest channel wins.
- R4: The fast outputs only consider channels 0 and 1. The normal outputs only consider channels 2 to 31. The two are resolved independently in the same cycle.
- R5: A pending source whose entry is greater than 31 raises neither request and never appears on any output.
- R6: When several pending sources share the winning channel, the lowest-numbered source is reported.
- R7: When no eligible source is pending for a host output, its request is low and its source and channel outputs are zero.
- R8: A pending change sampled on one clock edge appears on the outputs right after that edge. A map write takes effect on the outputs one edge after the edge that stores it.
- R9: Writes to an address at or above the number of map words change nothing, and reads from such an address return zero.
- R10: With the reset map, any pending source is reported on the normal outputs with channel 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_SRC | Pending flag per source |
| map_we_i | input | 1 | Map word write strobe |
| map_addr_i | input | ADDR_W | Map word address for write and read |
| map_wdata_i | input | 32 | Map word write data |
| map_rdata_o | output | 32 | Map word at map_addr_i (combinational) |
| fast_req_o | output | 1 | Fast request; also valid flag for the fast outputs |
| fast_src_o | output | SRC_IDX_W | Winning source for the fast request |
| fast_chan_o | output | 8 | Winning channel for the fast request |
| norm_req_o | output | 1 | Normal request; also valid flag for the normal outputs |
| norm_src_o | output | SRC_IDX_W | Winning source for the normal request |
| norm_chan_o | output | 8 | Winning channel for the normal request |

## Verification
A pending pattern driven on a falling edge is due on the outputs after the next rising edge, so the bench checks it on the following falling edge. A map write needs one extra rising edge: one edge stores the word and the next registers the new winner. The latency test looks half a cycle early to show the old value still holds, then looks on the due falling edge. Readback is combinational and is sampled a short delay after the address changes.

// File: rtl/cmip_pkg.sv
package cmip_pkg;
  localparam int CHAN_W     = 8;
  localparam int NUM_CHAN   = 32;
  localparam int FAST_CHANS = 2;
  localparam int PER_WORD   = 4;
  localparam int WORD_W     = CHAN_W * PER_WORD;
  localparam logic [CHAN_W-1:0] RESET_CHAN = 8'd15;

  typedef logic [CHAN_W-1:0] chan_t;
endpackage

// File: rtl/cmip_map_regs.sv
module cmip_map_regs
  import cmip_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [WORD_W-1:0]         rdata_o,
  output logic [NUM_SRC*CHAN_W-1:0] chan_flat_o
);
  localparam int NUM_WORDS = (NUM_SRC + PER_WORD - 1) / PER_WORD;

  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) words_q[w] <= {PER_WORD{RESET_CHAN}};
    end else if (we_i) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (addr_i == ADDR_W'(w)) words_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (addr_i == ADDR_W'(w)) rdata_o = words_q[w];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
    assign chan_flat_o[s*CHAN_W +: CHAN_W] =
      words_q[s/PER_WORD][(s%PER_WORD)*CHAN_W +: CHAN_W];
  end

  // R2: a write to a valid address is held in the addressed word
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i < ADDR_W'(NUM_WORDS)) |=> words_q[$past(addr_i)] == $past(wdata_i));

  // R9: writes outside the map leave every word untouched
  p_bad_addr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i >= ADDR_W'(NUM_WORDS)) |=> $stable(words_q));
endmodule

// File: rtl/cmip_resolver.sv
module cmip_resolver
  import cmip_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int SRC_IDX_W = 5,
  parameter int LO        = 0,
  parameter int HI        = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*CHAN_W-1:0] chan_flat_i,
  output logic                      req_o,
  output logic [SRC_IDX_W-1:0]      src_o,
  output chan_t                     chan_o
);
  logic                 found;
  logic [SRC_IDX_W-1:0] best_src;
  chan_t                best_ch;
  chan_t                ch;

  // Ascending scan with a strict compare keeps the lowest source on a tie.
  always_comb begin
    found    = 1'b0;
    best_src = '0;
    best_ch  = '0;
    ch       = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      ch = chan_flat_i[s*CHAN_W +: CHAN_W];
      if (pend_i[s] && ch >= CHAN_W'(LO) && ch <= CHAN_W'(HI) &&
          (!found || ch < best_ch)) begin
        found    = 1'b1;
        best_src = SRC_IDX_W'(s);
        best_ch  = ch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      src_o  <= '0;
      chan_o <= '0;
    end else begin
      req_o  <= found;
      src_o  <= best_src;
      chan_o <= best_ch;
    end
  end

  // R4: a raised request always carries a channel of this band
  p_chan_in_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (chan_o >= CHAN_W'(LO) && chan_o <= CHAN_W'(HI)));

  // R7: an idle output shows zero source and channel
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (src_o == '0 && chan_o == '0));

  // R5: the reported channel never exceeds the last mapped channel
  p_no_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> chan_o < CHAN_W'(NUM_CHAN));
endmodule

// File: rtl/cmip_prioritizer.sv
module cmip_prioritizer
  import cmip_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int SRC_IDX_W = 5,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   pend_i,
  input  logic                 map_we_i,
  input  logic [ADDR_W-1:0]    map_addr_i,
  input  logic [WORD_W-1:0]    map_wdata_i,
  output logic [WORD_W-1:0]    map_rdata_o,
  output logic                 fast_req_o,
  output logic [SRC_IDX_W-1:0] fast_src_o,
  output logic [CHAN_W-1:0]    fast_chan_o,
  output logic                 norm_req_o,
  output logic [SRC_IDX_W-1:0] norm_src_o,
  output logic [CHAN_W-1:0]    norm_chan_o
);
  localparam int NUM_HOSTS = 2;

  logic [NUM_SRC*CHAN_W-1:0] chan_flat;
  logic                      req_h  [NUM_HOSTS];
  logic [SRC_IDX_W-1:0]      src_h  [NUM_HOSTS];
  chan_t                     chan_h [NUM_HOSTS];

  cmip_map_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst_n(rst_n), .we_i(map_we_i), .addr_i(map_addr_i),
    .wdata_i(map_wdata_i), .rdata_o(map_rdata_o), .chan_flat_o(chan_flat)
  );

  // Host 0 takes the fast band, host 1 the rest of the channels.
  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
    localparam int BAND_LO = (h == 0) ? 0 : FAST_CHANS;
    localparam int BAND_HI = (h == 0) ? FAST_CHANS - 1 : NUM_CHAN - 1;
    cmip_resolver #(
      .NUM_SRC(NUM_SRC), .SRC_IDX_W(SRC_IDX_W), .LO(BAND_LO), .HI(BAND_HI)
    ) u_res (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .chan_flat_i(chan_flat),
      .req_o(req_h[h]), .src_o(src_h[h]), .chan_o(chan_h[h])
    );
  end

  assign fast_req_o  = req_h[0];
  assign fast_src_o  = src_h[0];
  assign fast_chan_o = chan_h[0];
  assign norm_req_o  = req_h[1];
  assign norm_src_o  = src_h[1];
  assign norm_chan_o = chan_h[1];

  // R8: no request can rise out of an idle pending vector
  p_req_from_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_req_o || norm_req_o) |-> $past(pend_i) != '0);
endmodule

// File: tb/test_cmip_prioritizer.sv
module test_cmip_prioritizer;
  localparam int NSRC = 20;
  localparam int IW   = 5;
  localparam int AW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] pend = '0;
  logic            we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            f_req, n_req;
  logic [IW-1:0]   f_src, n_src;
  logic [7:0]      f_ch, n_ch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cmip_prioritizer #(.NUM_SRC(NSRC), .SRC_IDX_W(IW), .ADDR_W(AW)) i_cmip_prioritizer (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .map_we_i(we), .map_addr_i(addr),
    .map_wdata_i(wdata), .map_rdata_o(rdata),
    .fast_req_o(f_req), .fast_src_o(f_src), .fast_chan_o(f_ch),
    .norm_req_o(n_req), .norm_src_o(n_src), .norm_chan_o(n_ch)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int fr, input int fs, input int fc,
                         input int nr, input int ns, input int nc);
    chk(req, "fast_req", f_req, fr);
    chk(req, "fast_src", f_src, fs);
    chk(req, "fast_chan", f_ch, fc);
    chk(req, "norm_req", n_req, nr);
    chk(req, "norm_src", n_src, ns);
    chk(req, "norm_chan", n_ch, nc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pend = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Ends on a falling edge with the word stored on the rising edge before it.
  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input logic [31:0] exp);
    addr = AW'(a);
    #1;
    chk(req, $sformatf("word %0d", a), int'(rdata), int'(exp));
  endtask

  // Drive pending on a falling edge, check on the next one.
  task automatic apply(input logic [NSRC-1:0] p);
    pend = p;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_out("R1", 0, 0, 0, 0, 0, 0);
    for (int w = 0; w < 5; w++) rd("R1", w, 32'h0F0F0F0F);
  endtask

  task automatic t_default15();
    do_reset();
    apply(NSRC'(1) << 7);
    chk_out("R10", 0, 0, 0, 1, 7, 15);
  endtask

  task automatic t_pack();
    do_reset();
    wr(1, 32'h031F0005);            // src4=5 src5=0 src6=31 src7=3
    rd("R2", 1, 32'h031F0005);
    apply(NSRC'(1) << 5);
    chk_out("R2", 1, 5, 0, 0, 0, 0);
    apply(NSRC'(1) << 6);
    chk_out("R2", 0, 0, 0, 1, 6, 31);
  endtask

  task automatic t_priority();
    do_reset();
    wr(0, 32'h0F0F0F14);            // src0=20
    wr(2, 32'h0F0F040F);            // src9=4
    wr(4, 32'h0C0F0F0F);            // src19=12
    apply((NSRC'(1) << 0) | (NSRC'(1) << 9) | (NSRC'(1) << 19));
    chk_out("R3", 0, 0, 0, 1, 9, 4);
    apply((NSRC'(1) << 0) | (NSRC'(1) << 19));
    chk_out("R3", 0, 0, 0, 1, 19, 12);
  endtask

  task automatic t_split();
    do_reset();
    wr(0, 32'h02010F0F);            // src2=1 src3=2
    apply((NSRC'(1) << 2) | (NSRC'(1) << 3));
    chk_out("R4", 1, 2, 1, 1, 3, 2);
  endtask

  task automatic t_unmapped();
    do_reset();
    wr(2, 32'hFF200F0F);            // src10=32 src11=255
    apply((NSRC'(1) << 10) | (NSRC'(1) << 11));
    chk_out("R5", 0, 0, 0, 0, 0, 0);
    apply((NSRC'(1) << 10) | (NSRC'(1) << 11) | (NSRC'(1) << 12));
    chk_out("R5", 0, 0, 0, 1, 12, 15);
  endtask

  task automatic t_tie();
    do_reset();
    wr(3, 32'h0F0F060F);            // src13=6
    wr(4, 32'h0F0F060F);            // src17=6
    apply((NSRC'(1) << 17) | (NSRC'(1) << 13) | (NSRC'(1) << 14));
    chk_out("R6", 0, 0, 0, 1, 13, 6);
  endtask

  task automatic t_idle();
    do_reset();
    wr(0, 32'h0F0F0F00);            // src0=0
    apply(NSRC'(1));
    chk_out("R7", 1, 0, 0, 0, 0, 0);
    apply('0);
    chk_out("R7", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    do_reset();
    pend = NSRC'(1) << 1;
    #5;
    chk("R8", "norm_req before edge", n_req, 0);
    @(negedge clk);
    chk("R8", "norm_req after edge", n_req, 1);
    wr(0, 32'h0F0F000F);            // src1=0
    chk("R8", "fast_req on store edge", f_req, 0);
    @(negedge clk);
    chk("R8", "fast_req one edge later", f_req, 1);
    chk("R8", "norm_req one edge later", n_req, 0);
  endtask

  task automatic t_bad_addr();
    do_reset();
    wr(5, 32'h00000000);
    wr(7, 32'h00000000);
    rd("R9", 5, 32'h0);
    rd("R9", 7, 32'h0);
    for (int w = 0; w < 5; w++) rd("R9", w, 32'h0F0F0F0F);
    @(negedge clk);
    apply(NSRC'(1));
    chk_out("R9", 0, 0, 0, 1, 0, 15);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default15();
    t_pack();
    t_priority();
    t_split();
    t_unmapped();
    t_tie();
    t_idle();
    t_latency();
    t_bad_addr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule